// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a multi-channel event timer. A shared main counter, kept outside the channel, is presented on `counter_i`. The channel holds a comparator and a period. When the counter reaches the comparator while the channel is armed and both the channel enable and the global enable are set, it emits a single-cycle `fire_o` pulse toward the interrupt routing logic.

The channel runs one-shot or periodic, with a full-width counter or a narrow mode that uses only the low half. In periodic mode each match advances the comparator by the period. Periods that were missed are skipped and not replayed. In narrow one-shot mode the channel also fires when the low half of the counter wraps before the match. Comparator writes arrive as half-word strobes from an external register decoder. The configuration bits are plain level inputs. The only exception is the set-value request, which is held inside the channel until the next comparator write consumes it.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the period reads zero, `fire_o` is low, and both capability outputs read 1 (periodic-capable, full-width-capable).
- R2: The reach test takes D = comparator minus counter, wrapped to the active width: all CNT_W bits in full mode, or only the low CNT_W/2 bits in narrow mode, where the upper counter bits are ignored. The counter has reached the comparator when D is zero or its top bit is set. An unsigned counter more than half the range ahead therefore does not count as reached.
- R3: Three events arm the channel: a rise of `ch_en_i` while `glb_en_i` is high; a rise of `glb_en_i` while `ch_en_i` is high and the comparator is not all ones; or a comparator write while both enables are high. A fire needs both enables high. Dropping either enable disarms the channel.
- R4: `fire_o` is registered. It is high for exactly the one cycle after the clock edge at which an armed channel sees the counter reach the comparator. A one-shot channel then disarms and does not fire again while the counter stays past.
- R5: In periodic mode with a nonzero period, a match gives one pulse and adds the period to the comparator. On each following cycle the period is added again while the counter is strictly past the comparator. No further pulse is produced until a new match.
- R6: A periodic channel whose period is zero behaves as one-shot: it fires once and leaves the comparator unchanged.
- R7: A low-half write replaces the comparator low half when the channel is one-shot or set-value is pending. In periodic mode it also loads the period low half. A high-half write replaces the comparator high half when the channel is one-shot or set-value is pending. Otherwise, in periodic mode, it loads only the period high half.
- R8: A pulse on `setval_set_i` makes set-value pending. Any comparator write, low or high, clears it.
- R9: The period's top usable bit is always cleared: bit 63 of the period in full mode (bit 31 of a high-half write), and bit 31 of a low-half write in narrow mode.
- R10: While narrow mode is selected, the upper halves of the comparator and the period are held at zero. This truncates them on entry. High-half period writes then have no effect, and periodic reloads wrap modulo 2^32.
- R11: A narrow one-shot channel that is armed fires an extra pulse when the low half of the counter decreases from one cycle to the next. It stays armed and fires again at the real match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| counter_i | input | CNT_W | Shared main counter value |
| glb_en_i | input | 1 | Global timer enable |
| ch_en_i | input | 1 | Channel enable |
| periodic_i | input | 1 | 1 = periodic, 0 = one-shot |
| narrow_i | input | 1 | 1 = low-half (32-bit) mode |
| setval_set_i | input | 1 | Pulse: make set-value pending |
| wr_lo_i | input | 1 | Comparator low-half write strobe |
| wr_hi_i | input | 1 | Comparator high-half write strobe |
| wr_data_i | input | CNT_W/2 | Write data for either half |
| fire_o | output | 1 | Single-cycle fire event |
| cmp_o | output | CNT_W | Current comparator |
| period_o | output | CNT_W | Current period |
| cap_periodic_o | output | 1 | Periodic capability flag |
| cap_wide_o | output | 1 | Full-width capability flag |

## Verification
The bench builds the channel with its default 64-bit counter, so the narrow mode works on 32-bit halves. Because the counter is a free input and not an internal count, the bench can jump it straight across the 2^32 low-half wrap and to more than 2^63 beyond the comparator. This reaches the sign-test, wrap-fire and truncation cases in a few cycles. It can also freeze the counter far past the comparator, which makes the one-period-per-cycle catch-up visible as a fixed final comparator value.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;

  typedef struct packed {
    logic periodic;
    logic narrow;
  } chan_mode_t;

  function automatic int half_width(input int w);
    return w / 2;
  endfunction

endpackage

// File: rtl/evt_cmp_pass.sv
module evt_cmp_pass #(
  parameter int W = 32
) (
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] cnt_i,
  output logic         reached_o,
  output logic         passed_o
);
  logic [W-1:0] diff;

  assign diff      = cmp_i - cnt_i;
  assign passed_o  = diff[W-1];
  assign reached_o = diff[W-1] | (diff == '0);
endmodule

// File: rtl/evt_cmp_wrap.sv
module evt_cmp_wrap #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt_i,
  output logic         wrap_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= cnt_i;
  end

  assign wrap_o = cnt_i < prev_q;
endmodule

// File: rtl/evt_cmp_store.sv
module evt_cmp_store
  import evt_cmp_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  chan_mode_t             mode_i,
  input  logic                   setval_set_i,
  input  logic                   wr_lo_i,
  input  logic                   wr_hi_i,
  input  logic [CNT_W/2-1:0]     wr_data_i,
  input  logic                   reload_i,
  output logic [CNT_W-1:0]       cmp_o,
  output logic [CNT_W-1:0]       per_o
);
  localparam int HALF_W = half_width(CNT_W);

  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic             setval_q;
  logic             wr_any;
  logic             take_cmp;

  assign wr_any   = wr_lo_i | wr_hi_i;
  assign take_cmp = !mode_i.periodic || setval_q;

  always_comb begin
    cmp_d = cmp_q;
    per_d = per_q;
    if (reload_i) cmp_d = cmp_q + per_q;
    if (wr_lo_i) begin
      if (take_cmp) cmp_d[HALF_W-1:0] = wr_data_i;
      if (mode_i.periodic) begin
        per_d[HALF_W-1:0] = wr_data_i;
        if (mode_i.narrow) per_d[HALF_W-1] = 1'b0;
      end
    end
    if (wr_hi_i) begin
      if (take_cmp) begin
        cmp_d[CNT_W-1:HALF_W] = wr_data_i;
      end else begin
        per_d[CNT_W-1:HALF_W] = wr_data_i;
        per_d[CNT_W-1]        = 1'b0;
      end
    end
    if (mode_i.narrow) begin
      cmp_d[CNT_W-1:HALF_W] = '0;
      per_d[CNT_W-1:HALF_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q    <= '1;
      per_q    <= '0;
      setval_q <= 1'b0;
    end else begin
      cmp_q    <= cmp_d;
      per_q    <= per_d;
      setval_q <= setval_set_i | (setval_q & !wr_any);
    end
  end

  assign cmp_o = cmp_q;
  assign per_o = per_q;

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (cmp_q == '1 && per_q == '0));

  // R9
  a_r9_period_top_clear: assert property (@(posedge clk) disable iff (rst)
    !per_q[CNT_W-1]);

  // R10
  a_r10_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i.narrow) && !$past(rst)) |->
      (cmp_q[CNT_W-1:HALF_W] == '0 && per_q[CNT_W-1:HALF_W] == '0));

  // R8
  a_r8_setval_self_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_any && !setval_set_i) |=> !setval_q);
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import evt_cmp_pkg::*;
#(
  parameter int CNT_W        = 64,
  parameter bit CAP_PERIODIC = 1'b1,
  parameter bit CAP_WIDE     = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNT_W-1:0]     counter_i,
  input  logic                 glb_en_i,
  input  logic                 ch_en_i,
  input  logic                 periodic_i,
  input  logic                 narrow_i,
  input  logic                 setval_set_i,
  input  logic                 wr_lo_i,
  input  logic                 wr_hi_i,
  input  logic [CNT_W/2-1:0]   wr_data_i,
  output logic                 fire_o,
  output logic [CNT_W-1:0]     cmp_o,
  output logic [CNT_W-1:0]     period_o,
  output logic                 cap_periodic_o,
  output logic                 cap_wide_o
);
  localparam int HALF_W = half_width(CNT_W);

  chan_mode_t       mode;
  logic [CNT_W-1:0] cmp_w, per_w;
  logic             reach_full, pass_full, reach_lo, pass_lo;
  logic             reached, passed, wrap_evt;
  logic             armed_q, catching_q, fire_q;
  logic             ch_en_q, glb_en_q;
  logic             live, wr_any, arm_evt, reload_mode;
  logic             match_fire, wrap_fire, fire_now, reload;

  assign mode.periodic = periodic_i;
  assign mode.narrow   = narrow_i;

  evt_cmp_store #(.CNT_W(CNT_W)) store_i (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode),
    .setval_set_i (setval_set_i),
    .wr_lo_i      (wr_lo_i),
    .wr_hi_i      (wr_hi_i),
    .wr_data_i    (wr_data_i),
    .reload_i     (reload),
    .cmp_o        (cmp_w),
    .per_o        (per_w)
  );

  evt_cmp_pass #(.W(CNT_W)) pass_full_i (
    .cmp_i     (cmp_w),
    .cnt_i     (counter_i),
    .reached_o (reach_full),
    .passed_o  (pass_full)
  );

  evt_cmp_pass #(.W(HALF_W)) pass_lo_i (
    .cmp_i     (cmp_w[HALF_W-1:0]),
    .cnt_i     (counter_i[HALF_W-1:0]),
    .reached_o (reach_lo),
    .passed_o  (pass_lo)
  );

  evt_cmp_wrap #(.W(HALF_W)) wrap_i (
    .clk    (clk),
    .rst    (rst),
    .cnt_i  (counter_i[HALF_W-1:0]),
    .wrap_o (wrap_evt)
  );

  assign reached     = narrow_i ? reach_lo : reach_full;
  assign passed      = narrow_i ? pass_lo  : pass_full;
  assign wr_any      = wr_lo_i | wr_hi_i;
  assign live        = armed_q & ch_en_i & glb_en_i;
  assign reload_mode = periodic_i & (per_w != '0);
  assign arm_evt     = (ch_en_i & !ch_en_q & glb_en_i) |
                       (glb_en_i & !glb_en_q & ch_en_i & (cmp_w != '1));

  assign match_fire  = live & !wr_any & !catching_q & reached;
  assign wrap_fire   = live & !wr_any & narrow_i & !periodic_i & wrap_evt;
  assign fire_now    = match_fire | wrap_fire;
  assign reload      = live & !wr_any & reload_mode &
                       ((!catching_q & reached) | (catching_q & passed));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b0;
      catching_q <= 1'b0;
      fire_q     <= 1'b0;
      ch_en_q    <= 1'b0;
      glb_en_q   <= 1'b0;
    end else begin
      ch_en_q  <= ch_en_i;
      glb_en_q <= glb_en_i;
      fire_q   <= fire_now;
      if (!ch_en_i || !glb_en_i)        armed_q <= 1'b0;
      else if (arm_evt || wr_any)       armed_q <= 1'b1;
      else if (match_fire && !reload_mode) armed_q <= 1'b0;
      if (!live || wr_any)              catching_q <= 1'b0;
      else if (reload)                  catching_q <= 1'b1;
      else if (catching_q && !passed)   catching_q <= 1'b0;
    end
  end

  assign fire_o         = fire_q;
  assign cmp_o          = cmp_w;
  assign period_o       = per_w;
  assign cap_periodic_o = CAP_PERIODIC;
  assign cap_wide_o     = CAP_WIDE;

  // R3
  a_r3_fire_needs_enables: assert property (@(posedge clk) disable iff (rst)
    fire_o |-> $past(ch_en_i && glb_en_i));

  // R4
  a_r4_no_repeat: assert property (@(posedge clk) disable iff (rst)
    (fire_o && $past(fire_o)) |-> $past(narrow_i && !periodic_i));

  // R6
  a_r6_zero_period_no_reload: assert property (@(posedge clk) disable iff (rst)
    (fire_o && $past(per_w == '0)) |-> $stable(cmp_o));
endmodule

// File: tb/evt_cmp_channel_tb.sv
`timescale 1ns/1ps
module evt_cmp_channel_tb_top;
  localparam int  CNT_W  = 64;
  localparam int  HALF_W = CNT_W / 2;
  localparam real HALF_P = 2.5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CNT_W-1:0]  counter = '0;
  logic              glb_en = 1'b0, ch_en = 1'b0, periodic = 1'b0, narrow = 1'b0;
  logic              setval_set = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
  logic [HALF_W-1:0] wr_data = '0;
  logic              fire;
  logic [CNT_W-1:0]  cmp, period;
  logic              cap_p, cap_w;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int    exp_q[$];
  string tag_q[$];

  always #(HALF_P) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  evt_cmp_channel #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .counter_i(counter), .glb_en_i(glb_en),
    .ch_en_i(ch_en), .periodic_i(periodic), .narrow_i(narrow),
    .setval_set_i(setval_set), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wr_data_i(wr_data), .fire_o(fire), .cmp_o(cmp), .period_o(period),
    .cap_periodic_o(cap_p), .cap_wide_o(cap_w)
  );

  // scoreboard monitor: pops expected fire cycles as pulses appear
  always @(negedge clk) begin
    if (!rst) begin
      if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        checks++; errors++;
        $display("FAIL %s: fire missing, actual=0 expected=1 at cycle %0d", tag_q[0], exp_q[0]);
        void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
      if (fire) begin
        checks++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          void'(exp_q.pop_front()); void'(tag_q.pop_front());
        end else begin
          errors++;
          $display("FAIL R4: unexpected fire at cycle %0d, actual=1 expected=0", cyc);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_fire(input int delta, input string tag);
    exp_q.push_back(cyc + delta);
    tag_q.push_back(tag);
  endtask

  task automatic write_half(input bit hi, input logic [HALF_W-1:0] d);
    wr_lo = !hi; wr_hi = hi; wr_data = d;
    tick(1);
    wr_lo = 1'b0; wr_hi = 1'b0;
  endtask

  task automatic req_setval();
    setval_set = 1'b1;
    tick(1);
    setval_set = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(HALF_P * 2 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 cmp", cmp, '1);
    chk("R1 period", period, '0);
    chk("R1 fire", {63'd0, fire}, 64'd0);
    chk("R1 cap periodic", {63'd0, cap_p}, 64'd1);
    chk("R1 cap wide", {63'd0, cap_w}, 64'd1);

    // R4 / R2: one-shot full width
    glb_en = 1'b1; counter = 64'd1000;
    write_half(1'b0, 32'd1500);
    write_half(1'b1, 32'd0);
    chk("R7 one-shot cmp", cmp, 64'd1500);
    ch_en = 1'b1;
    tick(2);
    counter = 64'd1500 + 64'h8000_0000_0000_0001; // R2: far ahead, sign says not reached
    tick(3);
    counter = 64'd1499;
    tick(2);
    counter = 64'd1500;
    expect_fire(1, "R4 match");
    tick(4);
    counter = 64'd2000; // R4: disarmed, no refire
    tick(3);
    ch_en = 1'b0;

    // R5 / R7 / R8: periodic catch-up
    periodic = 1'b1; counter = 64'd100;
    req_setval(); write_half(1'b1, 32'd0);
    req_setval(); write_half(1'b0, 32'd10);
    write_half(1'b0, 32'd20);
    chk("R8 setval cleared, cmp kept", cmp, 64'd10);
    chk("R7 period loaded", period, 64'd20);
    ch_en = 1'b1;
    expect_fire(2, "R5 first match");
    tick(10);
    chk("R5 catch-up cmp", cmp, 64'd110);
    counter = 64'd110;
    expect_fire(1, "R5 next match");
    tick(4);
    chk("R5 reload cmp", cmp, 64'd130);
    ch_en = 1'b0;
    tick(1);

    // R9 clamp full width, R7 high write to period only
    write_half(1'b1, 32'hFFFF_FFFF);
    chk("R9 period hi clamp", period, 64'h7FFF_FFFF_0000_0014);
    chk("R7 cmp untouched", cmp, 64'd130);
    req_setval(); write_half(1'b1, 32'd5);
    chk("R7 setval hi to cmp", cmp, 64'h0000_0005_0000_0082);
    chk("R7 setval hi period kept", period, 64'h7FFF_FFFF_0000_0014);

    // R10 narrow truncation
    narrow = 1'b1;
    tick(2);
    chk("R10 cmp truncated", cmp, 64'h82);
    chk("R10 period truncated", period, 64'h14);
    write_half(1'b1, 32'h123);
    chk("R10 hi period ignored", period, 64'h14);
    write_half(1'b0, 32'hFFFF_FFFF);
    chk("R9 narrow clamp", period, 64'h7FFF_FFFF);

    // R10 periodic narrow reload wraps mod 2^32, R2 upper bits ignored
    req_setval(); write_half(1'b0, 32'hFFFF_FFF0);
    write_half(1'b0, 32'h20);
    counter = 64'h1_FFFF_FFF0;
    ch_en = 1'b1;
    expect_fire(2, "R2 narrow match");
    tick(5);
    chk("R10 reload wrap", cmp, 64'h10);
    counter = 64'h2_0000_0010;
    expect_fire(1, "R2 upper ignored");
    tick(4);
    chk("R10 reload", cmp, 64'h30);
    ch_en = 1'b0;
    tick(1);

    // R11 one-shot narrow wrap event
    periodic = 1'b0; counter = 64'hFFFF_FFF0;
    write_half(1'b0, 32'h10);
    ch_en = 1'b1;
    tick(3);
    counter = 64'h1_0000_0002;
    expect_fire(1, "R11 wrap");
    tick(3);
    counter = 64'h1_0000_0010;
    expect_fire(1, "R11 match");
    tick(3);
    counter = 64'h1_0000_0005; // disarmed: drop gives no fire
    tick(3);
    ch_en = 1'b0;
    tick(1);

    // R6 zero period periodic
    narrow = 1'b0; periodic = 1'b1;
    req_setval(); write_half(1'b0, 32'd500);
    req_setval(); write_half(1'b1, 32'd0);
    write_half(1'b0, 32'd0);
    chk("R6 period zero", period, 64'd0);
    chk("R6 cmp set", cmp, 64'd500);
    counter = 64'd400;
    ch_en = 1'b1;
    tick(3);
    counter = 64'd500;
    expect_fire(1, "R6 single");
    tick(5);
    chk("R6 no reload", cmp, 64'd500);
    ch_en = 1'b0;
    tick(1);

    // R3 enable gating and arming
    periodic = 1'b0; glb_en = 1'b0; counter = 64'd800;
    write_half(1'b0, 32'd700);
    ch_en = 1'b1;
    tick(4);
    glb_en = 1'b1;
    expect_fire(2, "R3 global rise arms");
    tick(4);
    write_half(1'b0, 32'd900);
    tick(2);
    counter = 64'd900;
    expect_fire(1, "R3 write rearms");
    tick(4);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4: pending fires actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule